// File: doc/BRIEF.md
# Galloping Pattern Memory Self-Test Engine

This block is a built-in self-test sequencer for one single-port synchronous RAM of `2**AW` words. After a start pulse it takes over the RAM's address, write-enable and write-data lines and issues one operation per clock cycle. It follows the galloping pattern, which takes about four times the square of the depth in operations, so it suits shallow arrays or characterization runs. While it runs, it compares every word it reads with the value that word should hold.

The test has two passes. In the first the background is all zeros, and in the second it is all ones. Each pass first writes the background to every word. Each word then takes its turn as the pivot. The engine writes the pivot with the inverted background and reads it alternately with every other word, in ascending order. It then writes the background back into the pivot. The first wrong word the engine sees sets a sticky fail flag. It also records that word's address and whether the failing read was of the pivot. The test still runs to the end.

Top module: `galpat_engine`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are all low.
- R2: Each pass begins with one write of the background word to every address, from 0 up to N-1, one write per cycle.
- R3: After the fill, the pivot steps from 0 up to N-1. For each pivot, the engine first writes the inverted background to the pivot. Then, for every other address in ascending order with the pivot itself skipped, it reads the pivot and then reads that other address. Finally it writes the background back into the pivot.
- R4: The first pass uses the all-zeros background. The second pass uses the all-ones background, and `ram_wdata` is always all zeros or all ones.
- R5: A run takes exactly 2·(N + 2·N²) cycles with `busy` high, one RAM operation per cycle. `done` then rises and `busy` falls in the same cycle.
- R6: Read data arrives one cycle after the read is issued. A read of the pivot must return the inverted background, and a read of any other address must return the background.
- R7: On the first mismatch, `fail` goes high. `fail_addr` holds the address of that read, and `fail_is_base` is 1 if the failing read was of the pivot. Later mismatches in the same run change none of these outputs.
- R8: A mismatch does not shorten the run. Every operation of R5 is still issued.
- R9: `start` is ignored while `busy` is high. A `start` while idle or done launches a new run, clears `fail` and drops `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a run when not busy |
| ram_addr | output | AW | RAM address |
| ram_we | output | 1 | RAM write enable (a read when low during a run) |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, one cycle after the read |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run has finished |
| fail | output | 1 | A mismatch was seen in this run |
| fail_addr | output | AW | Address of the first mismatch |
| fail_is_base | output | 1 | First mismatch was a pivot read |

## Verification
The bench builds the engine with AW=3 and DW=8, which gives an 8-word RAM and a 272-operation run. At this size, the bench checks every operation of the nested sequence against a list it builds itself. The list covers the skip of the pivot at both the lowest and the highest address. Stuck bits and a write-coupling fault in the bench's RAM model are placed so that the first mismatch falls on a pivot read in some runs and on a neighbour read in others. The bench also pulses `start` during a run and starts a second run after a failing one.

// File: rtl/galpat_pkg.sv
package galpat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SETB,
        ST_RDB,
        ST_RDO,
        ST_RSTB,
        ST_DONE
    } gp_state_t;

    typedef struct packed {
        logic we;       // write this cycle
        logic re;       // read this cycle
        logic wbit;     // value replicated onto the write word
        logic ebit;     // value replicated into the expected read word
        logic is_base;  // operation targets the pivot
    } gp_op_t;

    function automatic gp_op_t op_of(gp_state_t st, logic bg);
        gp_op_t o;
        o = '0;
        case (st)
            ST_FILL: begin o.we = 1'b1; o.wbit = bg; end
            ST_SETB: begin o.we = 1'b1; o.wbit = ~bg; o.is_base = 1'b1; end
            ST_RDB:  begin o.re = 1'b1; o.ebit = ~bg; o.is_base = 1'b1; end
            ST_RDO:  begin o.re = 1'b1; o.ebit = bg; end
            ST_RSTB: begin o.we = 1'b1; o.wbit = bg; o.is_base = 1'b1; end
            default: o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/galpat_seq.sv
module galpat_seq
    import galpat_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output gp_op_t        op,
    output logic [AW-1:0] addr,
    output logic          launch,
    output logic          busy,
    output logic          done
);
    localparam logic [AW-1:0] AMAX = '1;
    localparam logic [AW-1:0] AONE = AW'(1);

    gp_state_t     state;
    logic          bg;
    logic [AW-1:0] base;
    logic [AW-1:0] oth;
    logic [AW-1:0] oth_nxt;
    logic          oth_last;

    assign launch = start && (state == ST_IDLE || state == ST_DONE);
    assign busy   = (state != ST_IDLE) && (state != ST_DONE);
    assign done   = (state == ST_DONE);
    assign op     = op_of(state, bg);

    always_comb begin
        case (state)
            ST_FILL, ST_RDO: addr = oth;
            default:         addr = base;
        endcase
    end

    always_comb begin
        oth_nxt  = oth + AONE;
        if (oth_nxt == base) oth_nxt = oth + AW'(2);
        oth_last = (oth == AMAX) || ((oth == AMAX - AONE) && (base == AMAX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            bg    <= 1'b0;
            base  <= '0;
            oth   <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: if (start) begin
                    state <= ST_FILL;
                    bg    <= 1'b0;
                    base  <= '0;
                    oth   <= '0;
                end
                ST_FILL: begin
                    if (oth == AMAX) begin
                        state <= ST_SETB;
                        base  <= '0;
                    end else begin
                        oth <= oth + AONE;
                    end
                end
                ST_SETB: begin
                    state <= ST_RDB;
                    oth   <= (base == '0) ? AONE : '0;
                end
                ST_RDB: state <= ST_RDO;
                ST_RDO: begin
                    if (oth_last) begin
                        state <= ST_RSTB;
                    end else begin
                        state <= ST_RDB;
                        oth   <= oth_nxt;
                    end
                end
                ST_RSTB: begin
                    if (base != AMAX) begin
                        base  <= base + AONE;
                        state <= ST_SETB;
                    end else if (bg) begin
                        state <= ST_DONE;
                    end else begin
                        bg    <= 1'b1;
                        oth   <= '0;
                        state <= ST_FILL;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_skip_pivot_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDO) |-> (oth != base));
    assert_alternate_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDB) |=> (state == ST_RDO));
    assert_bg_order_R4: assert property (@(posedge clk) disable iff (rst)
        (bg && !launch) |=> bg);
    assert_ignore_start_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start && state != ST_RSTB) |=> busy);

endmodule

// File: rtl/galpat_check.sv
module galpat_check
    import galpat_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  gp_op_t        op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] rdata,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic          fail_is_base
);
    logic          vld_q;
    logic          exp_q;
    logic          base_q;
    logic [AW-1:0] addr_q;
    logic          miss;

    assign miss = vld_q && (rdata != {DW{exp_q}});

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            exp_q  <= 1'b0;
            base_q <= 1'b0;
            addr_q <= '0;
        end else begin
            vld_q  <= op.re;
            exp_q  <= op.ebit;
            base_q <= op.is_base;
            addr_q <= addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fail         <= 1'b0;
            fail_addr    <= '0;
            fail_is_base <= 1'b0;
        end else if (miss && !fail) begin
            fail         <= 1'b1;
            fail_addr    <= addr_q;
            fail_is_base <= base_q;
        end
    end

    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (fail && !clr) |=> fail);
    assert_first_addr_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (fail && !clr) |=> ($stable(fail_addr) && $stable(fail_is_base)));
    assert_miss_sets_fail_R6: assert property (@(posedge clk) disable iff (rst)
        (miss && !clr) |=> fail);

endmodule

// File: rtl/galpat_engine.sv
module galpat_engine
    import galpat_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic          fail_is_base
);
    gp_op_t op;
    logic   launch;

    galpat_seq #(.AW(AW)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op     (op),
        .addr   (ram_addr),
        .launch (launch),
        .busy   (busy),
        .done   (done)
    );

    galpat_check #(.AW(AW), .DW(DW)) u_check (
        .clk          (clk),
        .rst          (rst),
        .clr          (launch),
        .op           (op),
        .addr         (ram_addr),
        .rdata        (ram_rdata),
        .fail         (fail),
        .fail_addr    (fail_addr),
        .fail_is_base (fail_is_base)
    );

    assign ram_we    = op.we;
    assign ram_wdata = {DW{op.wbit}};

    assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_solid_bg_R4: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_wdata == '0 || ram_wdata == '1));

endmodule

// File: tb/test_galpat_engine.sv
module test_galpat_engine;
    localparam int AW    = 3;
    localparam int DW    = 8;
    localparam int N     = 1 << AW;
    localparam int TOTAL = 2 * (N + 2 * N * N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] ram_addr;
    logic          ram_we;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata;
    logic          busy, done, fail, fail_is_base;
    logic [AW-1:0] fail_addr;

    int errors = 0;
    int checks = 0;

    // fault controls of the RAM model
    bit            sa1_en = 0, sa0_en = 0, cf_en = 0;
    int            sa1_addr = 0, sa0_addr = 0, cf_aggr = 0, cf_vic = 0;
    logic [DW-1:0] sa1_mask = '0, sa0_mask = '0;

    logic [DW-1:0] mem [N];

    // expected operation list
    bit            e_we [TOTAL];
    int            e_addr [TOTAL];
    logic [DW-1:0] e_wd [TOTAL];

    always #5 clk = ~clk;

    galpat_engine #(.AW(AW), .DW(DW)) i_galpat_engine (
        .clk(clk), .rst(rst), .start(start),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_is_base(fail_is_base)
    );

    initial for (int i = 0; i < N; i++) mem[i] = '0;

    always @(posedge clk) begin
        logic [DW-1:0] d;
        d = mem[ram_addr];
        if (sa1_en && int'(ram_addr) == sa1_addr) d = d | sa1_mask;
        if (sa0_en && int'(ram_addr) == sa0_addr) d = d & ~sa0_mask;
        ram_rdata <= d;
        if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
            if (cf_en && int'(ram_addr) == cf_aggr) mem[cf_vic][0] <= ~mem[cf_vic][0];
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic build_expected();
        int k = 0;
        for (int p = 0; p < 2; p++) begin
            logic [DW-1:0] b = (p == 0) ? '0 : '1;
            for (int a = 0; a < N; a++) begin
                e_we[k] = 1; e_addr[k] = a; e_wd[k] = b; k++;
            end
            for (int bc = 0; bc < N; bc++) begin
                e_we[k] = 1; e_addr[k] = bc; e_wd[k] = ~b; k++;
                for (int oc = 0; oc < N; oc++) begin
                    if (oc != bc) begin
                        e_we[k] = 0; e_addr[k] = bc; e_wd[k] = '0; k++;
                        e_we[k] = 0; e_addr[k] = oc; e_wd[k] = '0; k++;
                    end
                end
                e_we[k] = 1; e_addr[k] = bc; e_wd[k] = b; k++;
            end
        end
    endtask

    // runs one test, comparing each issued operation with the list
    task automatic run_galpat(input bit poke_mid, output int nops, output int nbad);
        int guard = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        nops = 0; nbad = 0;
        while (!done && guard < 2 * TOTAL) begin
            if (busy) begin
                if (nops < TOTAL) begin
                    if (ram_we !== e_we[nops] || int'(ram_addr) != e_addr[nops] ||
                        (e_we[nops] && ram_wdata !== e_wd[nops])) nbad++;
                end else nbad++;
                nops++;
            end
            start = (poke_mid && (nops == 50 || nops == 200)) ? 1'b1 : 1'b0;
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic clear_faults();
        sa1_en = 0; sa0_en = 0; cf_en = 0;
    endtask

    task automatic test_reset();
        check(!busy && !done && !fail, "R1 idle after reset", {busy, done, fail}, 0);
    endtask

    task automatic test_clean_run();
        int nops, nbad;
        clear_faults();
        run_galpat(0, nops, nbad);
        check(nbad == 0, "R2/R3/R4 operation sequence mismatches", nbad, 0);
        check(nops == TOTAL, "R5 busy cycle count", nops, TOTAL);
        check(done && !busy, "R5 done and not busy at end", {done, busy}, 2);
        check(!fail, "R6 clean memory passes", fail, 0);
    endtask

    task automatic test_start_ignored();
        int nops, nbad;
        clear_faults();
        run_galpat(1, nops, nbad);
        check(nbad == 0 && nops == TOTAL, "R9 start while busy ignored", nops, TOTAL);
    endtask

    task automatic test_fault(input string name, input int exp_addr, input bit exp_base);
        int nops, nbad;
        run_galpat(0, nops, nbad);
        check(fail, {name, " R6 fail raised"}, fail, 1);
        check(int'(fail_addr) == exp_addr, {name, " R7 first fail address"}, fail_addr, exp_addr);
        check(fail_is_base == exp_base, {name, " R7 pivot flag"}, fail_is_base, exp_base);
        check(nops == TOTAL && nbad == 0, {name, " R8 run completes"}, nops, TOTAL);
    endtask

    initial begin
        build_expected();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_clean_run();
        test_start_ignored();

        // stuck-at-1 on a neighbour: first seen reading address 5 as neighbour of pivot 0
        clear_faults(); sa1_en = 1; sa1_addr = 5; sa1_mask = 8'h01;
        test_fault("sa1@5", 5, 0);

        // stuck-at-0 at address 0: first seen on the pivot read of pivot 0
        clear_faults(); sa0_en = 1; sa0_addr = 0; sa0_mask = 8'h04;
        test_fault("sa0@0", 0, 1);

        // stuck-at-0 at address 3: first seen on the pivot read of pivot 3
        clear_faults(); sa0_en = 1; sa0_addr = 3; sa0_mask = 8'h02;
        test_fault("sa0@3", 3, 1);

        // writing address 2 flips bit 0 of address 6: first seen at 6 under pivot 2
        clear_faults(); cf_en = 1; cf_aggr = 2; cf_vic = 6;
        test_fault("cf2->6", 6, 0);

        // stuck-at-1 on the highest address: its pivot read at top address is clean in pass 0? no, neighbour read first
        clear_faults(); sa1_en = 1; sa1_addr = N - 1; sa1_mask = 8'h80;
        test_fault("sa1@top", N - 1, 0);

        // new run after a failing one clears the flag (R9)
        clear_faults();
        for (int i = 0; i < N; i++) mem[i] = '0;
        begin
            int nops, nbad;
            run_galpat(0, nops, nbad);
            check(!fail, "R9 restart clears fail", fail, 0);
            check(nops == TOTAL, "R9 restart full run", nops, TOTAL);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule